// File: doc/BRIEF.md
# Interleaved Round-Serial SHA-256 Compressor

This block computes the SHA-256 compression function for already padded 512-bit message blocks. It holds one round of datapath logic and runs every round of every block through it. The round is cut into four register stages. Four independent hashing contexts circulate around that ring, so each stage holds a different context in every cycle. Each context carries its own working variables a..h, its own 16-word schedule window, its own starting hash value and its own round counter.

The host presents a block, a 256-bit starting hash value and a tag on a valid/ready input. The input has back-pressure. A block is taken only on an edge where `in_valid` and `in_ready` are both high. `in_ready` is high only in a cycle where the ring slot about to enter the first stage is empty or is retiring its finished context. While `in_ready` is low, the host must keep its request stable or withdraw it, and nothing is consumed.

The result leaves as a one-cycle `out_valid` strobe carrying the digest and the tag given at load. The output has no back-pressure. The consumer must capture the result in the strobe cycle. The starting hash value is an input, so a chained multi-block message is hashed by feeding back each digest as the next block's starting value. Padding, nonce handling and digest comparison are done outside the block.

Top module: `sha256_interleave`

## Requirements
- R1: A block is accepted on a rising edge where both `in_valid` and `in_ready` are high. `in_ready` is high exactly when the ring slot reaching the entry stage at that edge is empty or is completing its context. After reset all four slots are empty.
- R2: The digest equals the 64-round compression of the block added word-wise, modulo 2^32, to the starting hash value. Word ordering is as follows.
  - Block bits [511:480] are schedule word 0.
  - Bits [255:224] of the starting value and of the digest hold hash word 0, which is variable a.
  - The remaining words follow in descending bit order.
- R3: For a block accepted at edge n, `out_valid` is high for exactly the one cycle that follows edge n+256. That is four clock edges per round over 64 rounds, plus one edge for the final addition.
- R4: Up to four contexts are in flight at once. After reset, four blocks offered on consecutive cycles are all accepted on consecutive edges. Each result returns with the tag given at its own load.
- R5: `in_valid` held high while `in_ready` is low has no effect. No extra result appears, and the results of the contexts already in flight are unchanged.
- R6: A slot accepts a new block on the same edge at which its previous context completes. The new block's result follows 256 edges later.
- R7: While reset is held, `in_ready` is high and `out_valid` is low.
- R8: Rounds 0 to 15 use the block's words directly, and rounds 16 to 63 use expanded schedule words. The standard starting value with the padded "abc" block yields ba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad. The padded empty message yields e3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855.
- R9: With the input kept supplied, the block sustains four digests per 256 cycles. Twelve blocks loaded in three full waves complete within 3*256+3 edges of the first load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A block is offered |
| in_ready | output | 1 | The entry slot can take a block at the next edge |
| in_block | input | 512 | Padded message block, word 0 in bits [511:480] |
| in_iv | input | 256 | Starting hash value, word 0 (a) in bits [255:224] |
| in_tag | input | TAG_W | Tag returned with the result |
| out_valid | output | 1 | One-cycle result strobe |
| out_digest | output | 256 | Digest, word 0 in bits [255:224] |
| out_tag | output | TAG_W | Tag of the completing block |

## Verification
The assertions check every cycle the following properties.
- An accepted load starts a fresh context at round zero carrying the new tag.
- A busy context reaching the entry stage always stands between rounds 1 and 64.
- The number of occupied slots changes only by loads and completions.
- The digest register holds between strobes.

Only the bench scenarios can show that the digests are arithmetically right against the standard vectors and a behavioural model. They also show the exact 256-edge latency, the reload of a slot at its completion edge, and that refused requests leave the in-flight results intact.

// File: rtl/sha_ilv_pkg.sv
package sha_ilv_pkg;

  typedef logic [31:0] word_t;

  localparam int N_SLOT = 4;
  localparam int ROUNDS = 64;
  localparam int RND_W  = $clog2(ROUNDS) + 1;
  localparam int KIX_W  = $clog2(ROUNDS);
  localparam int WIN    = 16;
  localparam int HWORDS = 8;
  localparam int BLK_W  = WIN * 32;
  localparam int DIG_W  = HWORDS * 32;

  // context state that travels around the ring; st[0]=a .. st[7]=h, w[0]=W[t]
  typedef struct packed {
    logic             busy;
    logic [RND_W-1:0] rnd;
    word_t [HWORDS-1:0] iv;
    word_t [HWORDS-1:0] st;
    word_t [WIN-1:0]    w;
  } ctx_t;

  typedef struct packed { word_t p; word_t sa; word_t sb; } s01_t;
  typedef struct packed { word_t p; word_t u;  word_t wn; } s12_t;
  typedef struct packed { word_t t1; word_t t2; word_t wn; } s23_t;

  localparam word_t RC [ROUNDS] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
    32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
    32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
    32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
    32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
    32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
    32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
    32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
    32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  function automatic word_t ror(input word_t x, input int unsigned n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic word_t big_s0(input word_t x);
    return ror(x, 2) ^ ror(x, 13) ^ ror(x, 22);
  endfunction

  function automatic word_t big_s1(input word_t x);
    return ror(x, 6) ^ ror(x, 11) ^ ror(x, 25);
  endfunction

  function automatic word_t sml_s0(input word_t x);
    return ror(x, 7) ^ ror(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sml_s1(input word_t x);
    return ror(x, 17) ^ ror(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t f_ch(input word_t e, input word_t f, input word_t g);
    return (e & f) ^ (~e & g);
  endfunction

  function automatic word_t f_maj(input word_t a, input word_t b, input word_t c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction

endpackage

// File: rtl/sha_entry_stage.sv
// Stage 0: retires finished contexts (feed-forward add), admits new blocks,
// starts h+K and the two schedule partial sums.
module sha_entry_stage
  import sha_ilv_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [BLK_W-1:0]   in_block,
  input  logic [DIG_W-1:0]   in_iv,
  input  logic [TAG_W-1:0]   in_tag,
  output logic               in_ready,
  input  ctx_t               ring_ctx,
  input  word_t              ring_k,
  input  logic [TAG_W-1:0]   ring_tag,
  output ctx_t               ctx_q,
  output s01_t               pipe_q,
  output logic [TAG_W-1:0]   tag_q,
  output logic               done_q,
  output logic [DIG_W-1:0]   digest_q,
  output logic [TAG_W-1:0]   done_tag_q
);

  logic             fin;
  logic             take;
  ctx_t             nx;
  s01_t             np;
  word_t            ksel;
  logic [TAG_W-1:0] ntag;
  logic [DIG_W-1:0] dig;

  always_comb begin
    fin      = ring_ctx.busy && (ring_ctx.rnd == RND_W'(ROUNDS));
    in_ready = !ring_ctx.busy || fin;
    take     = in_valid && in_ready;

    nx   = ring_ctx;
    ksel = ring_k;
    ntag = ring_tag;
    if (take) begin
      nx.busy = 1'b1;
      nx.rnd  = '0;
      for (int i = 0; i < HWORDS; i++) begin
        nx.iv[i] = in_iv[DIG_W-1-32*i -: 32];
        nx.st[i] = in_iv[DIG_W-1-32*i -: 32];
      end
      for (int i = 0; i < WIN; i++) begin
        nx.w[i] = in_block[BLK_W-1-32*i -: 32];
      end
      ksel = RC[0];
      ntag = in_tag;
    end else if (fin) begin
      nx.busy = 1'b0;
    end

    np.p  = nx.st[7] + ksel;
    np.sa = sml_s1(nx.w[14]) + nx.w[9];
    np.sb = sml_s0(nx.w[1]) + nx.w[0];

    for (int i = 0; i < HWORDS; i++) begin
      dig[DIG_W-1-32*i -: 32] = ring_ctx.iv[i] + ring_ctx.st[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_q      <= '0;
      pipe_q     <= '0;
      tag_q      <= '0;
      done_q     <= 1'b0;
      digest_q   <= '0;
      done_tag_q <= '0;
    end else begin
      ctx_q  <= nx;
      pipe_q <= np;
      tag_q  <= ntag;
      done_q <= fin;
      if (fin) begin
        digest_q   <= dig;
        done_tag_q <= ring_tag;
      end
    end
  end

  p_accept_start_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (ctx_q.busy && ctx_q.rnd == '0 && tag_q == $past(in_tag)));

  p_round_window_r3: assert property (@(posedge clk) disable iff (rst)
    ring_ctx.busy |-> (ring_ctx.rnd >= RND_W'(1) && ring_ctx.rnd <= RND_W'(ROUNDS)));

  p_digest_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> $stable(digest_q));

endmodule

// File: rtl/sha_mix_stage.sv
// Stage 1: adds W[t], forms Sigma1(e)+Ch, and closes the schedule sum.
module sha_mix_stage
  import sha_ilv_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  ctx_t             ctx_d,
  input  s01_t             pipe_d,
  input  logic [TAG_W-1:0] tag_d,
  output ctx_t             ctx_q,
  output s12_t             pipe_q,
  output logic [TAG_W-1:0] tag_q
);

  s12_t np;

  always_comb begin
    np.p  = pipe_d.p + ctx_d.w[0];
    np.u  = big_s1(ctx_d.st[4]) + f_ch(ctx_d.st[4], ctx_d.st[5], ctx_d.st[6]);
    np.wn = pipe_d.sa + pipe_d.sb;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_q  <= '0;
      pipe_q <= '0;
      tag_q  <= '0;
    end else begin
      ctx_q  <= ctx_d;
      pipe_q <= np;
      tag_q  <= tag_d;
    end
  end

endmodule

// File: rtl/sha_sum_stage.sv
// Stage 2: forms T1 and T2.
module sha_sum_stage
  import sha_ilv_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  ctx_t             ctx_d,
  input  s12_t             pipe_d,
  input  logic [TAG_W-1:0] tag_d,
  output ctx_t             ctx_q,
  output s23_t             pipe_q,
  output logic [TAG_W-1:0] tag_q
);

  s23_t np;

  always_comb begin
    np.t1 = pipe_d.p + pipe_d.u;
    np.t2 = big_s0(ctx_d.st[0]) + f_maj(ctx_d.st[0], ctx_d.st[1], ctx_d.st[2]);
    np.wn = pipe_d.wn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_q  <= '0;
      pipe_q <= '0;
      tag_q  <= '0;
    end else begin
      ctx_q  <= ctx_d;
      pipe_q <= np;
      tag_q  <= tag_d;
    end
  end

endmodule

// File: rtl/sha_commit_stage.sv
// Stage 3: writes the new working variables, slides the schedule window,
// advances the round and fetches the next round constant off the adder path.
module sha_commit_stage
  import sha_ilv_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  ctx_t             ctx_d,
  input  s23_t             pipe_d,
  input  logic [TAG_W-1:0] tag_d,
  output ctx_t             ctx_q,
  output word_t            k_q,
  output logic [TAG_W-1:0] tag_q
);

  ctx_t             nx;
  logic [RND_W-1:0] rn;

  always_comb begin
    nx    = ctx_d;
    rn    = ctx_d.rnd + RND_W'(1);
    nx.rnd = rn;
    nx.st[0] = pipe_d.t1 + pipe_d.t2;
    nx.st[1] = ctx_d.st[0];
    nx.st[2] = ctx_d.st[1];
    nx.st[3] = ctx_d.st[2];
    nx.st[4] = ctx_d.st[3] + pipe_d.t1;
    nx.st[5] = ctx_d.st[4];
    nx.st[6] = ctx_d.st[5];
    nx.st[7] = ctx_d.st[6];
    for (int i = 0; i < WIN - 1; i++) begin
      nx.w[i] = ctx_d.w[i+1];
    end
    nx.w[WIN-1] = pipe_d.wn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_q <= '0;
      k_q   <= '0;
      tag_q <= '0;
    end else begin
      ctx_q <= nx;
      k_q   <= RC[rn[KIX_W-1:0]];
      tag_q <= tag_d;
    end
  end

endmodule

// File: rtl/sha256_interleave.sv
module sha256_interleave
  import sha_ilv_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [511:0]       in_block,
  input  logic [255:0]       in_iv,
  input  logic [TAG_W-1:0]   in_tag,
  output logic               out_valid,
  output logic [255:0]       out_digest,
  output logic [TAG_W-1:0]   out_tag
);

  ctx_t             ctx0, ctx1, ctx2, ctx3;
  s01_t             p01;
  s12_t             p12;
  s23_t             p23;
  word_t            k3;
  logic [TAG_W-1:0] tag0, tag1, tag2, tag3;

  sha_entry_stage #(.TAG_W(TAG_W)) u_entry (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_block(in_block), .in_iv(in_iv), .in_tag(in_tag),
    .in_ready(in_ready),
    .ring_ctx(ctx3), .ring_k(k3), .ring_tag(tag3),
    .ctx_q(ctx0), .pipe_q(p01), .tag_q(tag0),
    .done_q(out_valid), .digest_q(out_digest), .done_tag_q(out_tag)
  );

  sha_mix_stage #(.TAG_W(TAG_W)) u_mix (
    .clk(clk), .rst(rst),
    .ctx_d(ctx0), .pipe_d(p01), .tag_d(tag0),
    .ctx_q(ctx1), .pipe_q(p12), .tag_q(tag1)
  );

  sha_sum_stage #(.TAG_W(TAG_W)) u_sum (
    .clk(clk), .rst(rst),
    .ctx_d(ctx1), .pipe_d(p12), .tag_d(tag1),
    .ctx_q(ctx2), .pipe_q(p23), .tag_q(tag2)
  );

  sha_commit_stage #(.TAG_W(TAG_W)) u_commit (
    .clk(clk), .rst(rst),
    .ctx_d(ctx2), .pipe_d(p23), .tag_d(tag2),
    .ctx_q(ctx3), .k_q(k3), .tag_q(tag3)
  );

  logic [N_SLOT-1:0] occ;
  assign occ = {ctx3.busy, ctx2.busy, ctx1.busy, ctx0.busy};

  // slot population moves only through accepted loads and completions
  p_slot_count_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(occ) == $countones($past(occ))
                       + int'($past(in_valid && in_ready && !rst))
                       - int'(out_valid));

endmodule

// File: tb/tb_sha256_interleave.sv
`timescale 1ns/1ps
module tb_sha256_interleave;

  localparam int TAG_W = 4;
  localparam int LAT   = 256;

  logic             clk, rst, in_valid, in_ready, out_valid;
  logic [511:0]     in_block;
  logic [255:0]     in_iv, out_digest;
  logic [TAG_W-1:0] in_tag, out_tag;

  sha256_interleave #(.TAG_W(TAG_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_block(in_block), .in_iv(in_iv), .in_tag(in_tag),
    .out_valid(out_valid), .out_digest(out_digest), .out_tag(out_tag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    int               due;
    logic [TAG_W-1:0] tag;
    logic [255:0]     dig;
    string            req;
  } exp_t;

  exp_t         expq[$];
  int           checks = 0, fails = 0;
  int           edge_n = 0;
  int           free_at[4];
  int           done_cnt = 0, last_done = 0;
  logic [31:0]  kt[64];
  logic [255:0] pend_dig;
  string        pend_req;
  bit           run = 0;

  localparam logic [255:0] STD_IV  = 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;
  localparam logic [255:0] ABC_DIG = 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
  localparam logic [255:0] NIL_DIG = 256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] ref_hash(input logic [255:0] iv, input logic [511:0] blk);
    logic [31:0] w[64];
    logic [31:0] v[8];
    logic [31:0] t1, t2;
    logic [255:0] r;
    for (int t = 0; t < 16; t++) w[t] = blk[511-32*t -: 32];
    for (int t = 16; t < 64; t++)
      w[t] = (rr(w[t-2],17) ^ rr(w[t-2],19) ^ (w[t-2] >> 10)) + w[t-7]
           + (rr(w[t-15],7) ^ rr(w[t-15],18) ^ (w[t-15] >> 3)) + w[t-16];
    for (int i = 0; i < 8; i++) v[i] = iv[255-32*i -: 32];
    for (int t = 0; t < 64; t++) begin
      t1 = v[7] + (rr(v[4],6) ^ rr(v[4],11) ^ rr(v[4],25))
         + ((v[4] & v[5]) ^ (~v[4] & v[6])) + kt[t] + w[t];
      t2 = (rr(v[0],2) ^ rr(v[0],13) ^ rr(v[0],22))
         + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      for (int i = 7; i > 0; i--) v[i] = v[i-1];
      v[4] = v[4] + t1;
      v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) r[255-32*i -: 32] = iv[255-32*i -: 32] + v[i];
    return r;
  endfunction

  function automatic logic [511:0] rnd_block();
    logic [511:0] b;
    for (int i = 0; i < 16; i++) b[32*i +: 32] = $urandom;
    return b;
  endfunction

  function automatic logic [255:0] rnd_iv();
    logic [255:0] b;
    for (int i = 0; i < 8; i++) b[32*i +: 32] = $urandom;
    return b;
  endfunction

  // round constants from the fractional cube roots of the first 64 primes
  initial begin
    int n, cnt;
    bit pr;
    real c, fr;
    n = 2; cnt = 0;
    while (cnt < 64) begin
      pr = 1;
      for (int d = 2; d * d <= n; d++) if (n % d == 0) pr = 0;
      if (pr) begin
        c  = $pow(real'(n), 1.0 / 3.0);
        c  = c - (c * c * c - real'(n)) / (3.0 * c * c);
        fr = c - $floor(c);
        kt[cnt] = 32'(longint'($floor(fr * 4294967296.0)));
        cnt++;
      end
      n++;
    end
  end

  // behavioural model: four slots in rotation, acceptance decided per edge
  always @(posedge clk) begin
    exp_t e;
    if (!rst) begin
      edge_n++;
      if (in_valid && free_at[edge_n % 4] <= edge_n) begin
        free_at[edge_n % 4] = edge_n + LAT;
        e.due = edge_n + LAT;
        e.tag = in_tag;
        e.dig = pend_dig;
        e.req = pend_req;
        expq.push_back(e);
      end
    end
  end

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    bit rexp, dexp;
    if (!rst && run) begin
      rexp = (free_at[(edge_n + 1) % 4] <= edge_n + 1);
      chk(in_ready == rexp, "R1", "in_ready", 256'(in_ready), 256'(rexp));
      dexp = (expq.size() > 0) && (expq[0].due == edge_n);
      chk(out_valid == dexp, "R3", "out_valid timing", 256'(out_valid), 256'(dexp));
      if (dexp) begin
        chk(out_tag == expq[0].tag, "R4", "result tag", 256'(out_tag), 256'(expq[0].tag));
        chk(out_digest == expq[0].dig, expq[0].req, "digest", out_digest, expq[0].dig);
        done_cnt++;
        last_done = edge_n;
      end
      while (expq.size() > 0 && expq[0].due <= edge_n) void'(expq.pop_front());
    end
  end

  task automatic send(input logic [511:0] b, input logic [255:0] iv, input logic [TAG_W-1:0] tg,
                      input logic [255:0] dig, input string req, output int acc);
    @(negedge clk);
    in_block = b; in_iv = iv; in_tag = tg; pend_dig = dig; pend_req = req;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    acc = edge_n + 1;
    @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog: actual no completion expected completion within limit");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int a1[4], a2[4], a3[4];
    logic [511:0] abc_blk, nil_blk, b;
    logic [255:0] iv;
    for (int i = 0; i < 4; i++) free_at[i] = 0;
    rst = 1'b1; in_valid = 1'b0; in_block = '0; in_iv = '0; in_tag = '0;
    pend_dig = '0; pend_req = "R2";

    abc_blk = '0; abc_blk[511:480] = 32'h61626380; abc_blk[31:0] = 32'h00000018;
    nil_blk = '0; nil_blk[511:480] = 32'h80000000;

    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R7", "in_ready in reset", 256'(in_ready), 256'(1));
    chk(out_valid == 1'b0, "R7", "out_valid in reset", 256'(out_valid), 256'(0));
    chk(ref_hash(STD_IV, abc_blk) == ABC_DIG, "R8", "bench model abc", ref_hash(STD_IV, abc_blk), ABC_DIG);
    rst = 1'b0;
    run = 1;

    // wave 1: standard vectors plus random blocks, back to back (R4, R8, R2)
    send(abc_blk, STD_IV, 4'd1, ABC_DIG, "R8", a1[0]);
    send(nil_blk, STD_IV, 4'd2, NIL_DIG, "R8", a1[1]);
    b = rnd_block();
    send(b, STD_IV, 4'd3, ref_hash(STD_IV, b), "R2", a1[2]);
    b = rnd_block(); iv = rnd_iv();
    send(b, iv, 4'd4, ref_hash(iv, b), "R2", a1[3]);
    for (int i = 1; i < 4; i++)
      chk(a1[i] == a1[i-1] + 1, "R4", "consecutive accept edge", 256'(a1[i]), 256'(a1[i-1] + 1));

    // requests while every slot is busy must be ignored (R5)
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      in_block = rnd_block(); in_iv = rnd_iv(); in_tag = 4'hf; in_valid = 1'b1;
    end
    @(negedge clk) in_valid = 1'b0;

    // wave 2 reloads each slot on its completion edge (R6)
    for (int i = 0; i < 4; i++) begin
      b = rnd_block(); iv = rnd_iv();
      send(b, iv, 4'(8 + i), ref_hash(iv, b), "R2", a2[i]);
    end
    for (int i = 0; i < 4; i++)
      chk(a2[i] == a1[i] + LAT, "R6", "reload edge", 256'(a2[i]), 256'(a1[i] + LAT));

    // wave 3 keeps the ring full (R9)
    for (int i = 0; i < 4; i++) begin
      b = rnd_block(); iv = rnd_iv();
      send(b, iv, 4'(12 + i), ref_hash(iv, b), "R2", a3[i]);
    end
    @(negedge clk) in_valid = 1'b0;
    for (int i = 0; i < 4; i++)
      chk(a3[i] == a2[i] + LAT, "R6", "reload edge wave 3", 256'(a3[i]), 256'(a2[i] + LAT));

    while (expq.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(done_cnt == 12, "R9", "result count", 256'(done_cnt), 256'(12));
    chk(last_done - a1[0] <= 3 * LAT + 3, "R9", "span of twelve results",
        256'(last_done - a1[0]), 256'(3 * LAT + 3));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule